// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Queued Break

This block is the transmit half of an asynchronous serial port. A single-entry holding register takes one byte at a time from a write strobe. At each character boundary the byte moves into a shift register, and the shift register sends it on the serial line at one bit per baud tick. Because the holding register empties at the moment of that transfer, the next byte can be written while the current one is still on the line. Frames then follow one another with no gap.

The block can also force the line low for whole character times, which sends a break. A break is queued each time the send-break control rises, and breaks keep coming back to back for as long as the control stays high. After the last queued break the line returns high for one bit time before any further character starts. Whenever the transmitter is switched on, it first sends a preamble character of all ones. A complete flag reports whether the shifter is idle, that is, whether no preamble, data, break or post-break stop bit is being sent.

The baud tick comes from an external divider. Character boundaries, and all the decisions taken there, happen only on a tick.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset the serial output is 1, the holding-empty flag is 1 and the complete flag is 1.
- R2: A data character occupies ten consecutive bit times, one per baud tick. Its first bit time is a start bit of 0. The next eight carry the byte, bit 0 first. The last is a stop bit of 1.
- R3: A write clears the holding-empty flag. The byte moves into the shifter at the next character boundary, and the flag returns to 1 in that same cycle. A byte written during a character follows that character with no idle bit time in between.
- R4: After the enable input rises, the first character sent is a preamble of ten bit times at 1. A byte already waiting is sent after it, and the complete flag is 0 throughout the preamble.
- R5: A rising edge on the send-break input queues a break, even if that input drops again before the next tick. A break is ten bit times with the serial output at 0.
- R6: While the send-break input stays 1, break characters follow one another with no gap. A hold that ends inside the 25th bit time after the first break began gives exactly 30 low bit times.
- R7: After the last queued break, exactly one bit time at 1 is sent before the next character or before going idle.
- R8: At a character boundary a pending break wins over a waiting byte. The byte stays in the holding register (holding-empty flag 0) until the break and its stop bit have been sent, and then goes out unchanged.
- R9: The complete flag is 0 during every preamble, data, break and stop bit time. It returns to 1 on the first tick after the last bit of the last character, when nothing is pending.
- R10: While the enable input is 0, no character starts. The serial output stays 1, the complete flag stays 1, and a written byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| xmit_en | input | 1 | Transmitter enable; a rising edge queues a preamble |
| send_brk | input | 1 | Send-break control |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register has no waiting byte |
| xmit_done | output | 1 | No character of any kind is being sent |

## Verification
The bench sends all 256 byte values back to back, each written during the previous frame. This exposes a wrong bit order, a bit time lost or doubled at the boundary, or a holding register that empties too late, which would add an idle gap. A break pulse shorter than a tick must still give a full ten-bit break followed by exactly one high bit. A break held for 25 ticks must give exactly 30 low bit times. A design that only acted on the edge would stop after ten, and one that did not finish the current character would cut the run short. A byte that is waiting when a break is requested must come out only after the break's stop bit. A design that got the priority wrong would let the byte go first or would drop it. The enable test checks that nothing starts while the transmitter is off, and that a preamble goes out before a held byte once it is switched on.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRE   = 3'd1,
      ST_DATA  = 3'd2,
      ST_BRK   = 3'd3,
      ST_BSTOP = 3'd4
   } tx_state_e;

endpackage

// File: rtl/utx_brk_queue.sv
module utx_brk_queue (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic take,
   output logic pending
);

   logic req_d;
   logic queued;
   logic req_rise;

   assign req_rise = req & ~req_d;
   assign pending  = queued | req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d  <= 1'b0;
         queued <= 1'b0;
      end else begin
         req_d  <= req;
         queued <= (queued | req_rise) & ~take;
      end
   end

   // R5
   rise_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rise && !take) |=> pending);

endmodule

// File: rtl/utx_hold_reg.sv
module utx_hold_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             load,
   output logic [WIDTH-1:0] data_out,
   output logic             empty
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= '0;
         empty    <= 1'b1;
      end else if (wr_en) begin
         data_out <= wr_data;
         empty    <= 1'b0;
      end else if (load) begin
         empty    <= 1'b1;
      end
   end

   // R3
   load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !empty);

   // R3
   empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty) |-> $past(load));

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
   parameter int FRAME_BITS = 10,
   localparam int CW        = $clog2(FRAME_BITS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] frame_in,
   input  logic [CW-1:0]         last_idx,
   output logic                  txd,
   output logic                  at_end
);

   logic [FRAME_BITS-1:0] sh;
   logic [CW-1:0]         cnt;
   logic [CW-1:0]         len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '1;
         cnt   <= '0;
         len_q <= '0;
      end else if (load) begin
         sh    <= frame_in;
         cnt   <= '0;
         len_q <= last_idx;
      end else if (tick) begin
         sh    <= {1'b1, sh[FRAME_BITS-1:1]};
         cnt   <= cnt + 1'b1;
      end
   end

   assign txd    = sh[0];
   assign at_end = (cnt == len_q);

   // R2
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(txd));

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
   parameter int DATA_BITS = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 baud_tick,
   input  logic                 wr_en,
   input  logic [DATA_BITS-1:0] wr_data,
   input  logic                 xmit_en,
   input  logic                 send_brk,
   output logic                 txd,
   output logic                 hold_empty,
   output logic                 xmit_done
);
   import uart_brk_tx_pkg::*;

   localparam int FRAME_BITS = DATA_BITS + 2;
   localparam int CW         = $clog2(FRAME_BITS);
   localparam logic [CW-1:0] LAST_FULL = CW'(FRAME_BITS - 1);
   localparam logic [CW-1:0] LAST_ONE  = '0;

   generate
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_width
         $error("uart_brk_tx: DATA_BITS must lie between 5 and 9");
      end
   endgenerate

   tx_state_e             state, nxt_state;
   logic [DATA_BITS-1:0]  hold_data;
   logic [DATA_BITS-1:0]  ordered;
   logic [FRAME_BITS-1:0] frame_sel;
   logic [CW-1:0]         len_sel;
   logic                  at_end;
   logic                  boundary;
   logic                  sh_load;
   logic                  take_brk;
   logic                  take_pre;
   logic                  ld_data;
   logic                  brk_pend;
   logic                  en_d;
   logic                  pre_q;

   // bit order of the data field
   generate
      if (LSB_FIRST) begin : g_lsb
         assign ordered = hold_data;
      end else begin : g_msb
         for (genvar i = 0; i < DATA_BITS; i++) begin : g_rev
            assign ordered[i] = hold_data[DATA_BITS-1-i];
         end
      end
   endgenerate

   utx_hold_reg #(.WIDTH(DATA_BITS)) i_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .load     (ld_data),
      .data_out (hold_data),
      .empty    (hold_empty)
   );

   utx_brk_queue i_brkq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (send_brk),
      .take    (take_brk),
      .pending (brk_pend)
   );

   utx_shifter #(.FRAME_BITS(FRAME_BITS)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .load     (sh_load),
      .frame_in (frame_sel),
      .last_idx (len_sel),
      .txd      (txd),
      .at_end   (at_end)
   );

   // preamble request on enable rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d  <= 1'b0;
         pre_q <= 1'b0;
      end else begin
         en_d  <= xmit_en;
         pre_q <= (pre_q | (xmit_en & ~en_d)) & ~take_pre;
      end
   end

   assign boundary = baud_tick && ((state == ST_IDLE) || at_end);

   // choice of next character at a boundary
   always_comb begin
      nxt_state = state;
      sh_load   = 1'b0;
      frame_sel = '1;
      len_sel   = LAST_FULL;
      take_brk  = 1'b0;
      take_pre  = 1'b0;
      ld_data   = 1'b0;
      if (boundary) begin
         if (!xmit_en) begin
            nxt_state = ST_IDLE;
         end else if (pre_q) begin
            nxt_state = ST_PRE;
            sh_load   = 1'b1;
            take_pre  = 1'b1;
         end else if (brk_pend) begin
            nxt_state = ST_BRK;
            sh_load   = 1'b1;
            frame_sel = '0;
            take_brk  = 1'b1;
         end else if (state == ST_BRK) begin
            nxt_state = ST_BSTOP;
            sh_load   = 1'b1;
            len_sel   = LAST_ONE;
         end else if (!hold_empty) begin
            nxt_state = ST_DATA;
            sh_load   = 1'b1;
            ld_data   = 1'b1;
            frame_sel = {1'b1, ordered, 1'b0};
         end else begin
            nxt_state = ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt_state;
   end

   assign xmit_done = (state == ST_IDLE);

   // R9
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xmit_done |-> txd);

   // R9
   done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xmit_done) |-> $past(baud_tick));

   // R4
   pre_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRE) |-> txd);

   // R6
   brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BRK) |-> !txd);

   // R7
   brk_then_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA) |-> ($past(state) != ST_BRK));

   // R10
   off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xmit_en && xmit_done) |=> xmit_done);

endmodule

// File: tb/test_uart_brk_tx.sv
module test_uart_brk_tx;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_GAP   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       xmit_en = 1'b0;
   logic       send_brk = 1'b0;
   logic       txd, hold_empty, xmit_done;

   int n_chk  = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_brk_tx i_uart_brk_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .xmit_en    (xmit_en),
      .send_brk   (send_brk),
      .txd        (txd),
      .hold_empty (hold_empty),
      .xmit_done  (xmit_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick_get(output bit b);
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
      b = txd;
      repeat (TICK_GAP - 2) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      bit b;
      bit bad;
      int zeros;
      logic [9:0] got, exp;
      logic [7:0] val;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd", txd, 1);
      chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
      chk(xmit_done == 1'b1, "R1 xmit_done", xmit_done, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10 disabled: nothing starts, byte kept
      wr(8'h3C);
      bad = 1'b0;
      for (int t = 0; t < 12; t++) begin
         tick_get(b);
         if (b !== 1'b1 || xmit_done !== 1'b1) bad = 1'b1;
      end
      chk(!bad, "R10 line idle while off", bad, 0);
      chk(hold_empty == 1'b0, "R10 byte kept", hold_empty, 0);

      // R4 preamble after enable
      @(negedge clk) xmit_en = 1'b1;
      bad = 1'b0;
      for (int t = 0; t < 10; t++) begin
         tick_get(b);
         if (b !== 1'b1 || xmit_done !== 1'b0 || hold_empty !== 1'b0) bad = 1'b1;
      end
      chk(!bad, "R4 preamble ten ones", bad, 0);

      // R2 R3 all byte values back to back
      for (int k = 0; k <= 256; k++) begin
         val = (k == 0) ? 8'h3C : 8'(k - 1);
         exp = {1'b1, val, 1'b0};
         tick_get(b);
         got[0] = b;
         chk(hold_empty == 1'b1, "R3 empty at load", hold_empty, 1);
         if (k < 256) wr(8'(k));
         bad = 1'b0;
         for (int i = 1; i < 10; i++) begin
            tick_get(b);
            got[i] = b;
            if (xmit_done !== 1'b0) bad = 1'b1;
         end
         chk(got == exp, "R2 frame bits", int'(got), int'(exp));
         chk(!bad, "R9 busy during data", bad, 0);
      end
      tick_get(b);
      chk(xmit_done == 1'b1, "R9 idle after last stop", xmit_done, 1);
      chk(b == 1'b1, "R9 line high idle", b, 1);

      // R5 short break pulse
      @(negedge clk) send_brk = 1'b1;
      @(negedge clk) send_brk = 1'b0;
      bad = 1'b0;
      for (int t = 0; t < 10; t++) begin
         tick_get(b);
         if (b !== 1'b0 || xmit_done !== 1'b0) bad = 1'b1;
      end
      chk(!bad, "R5 one full break", bad, 0);
      tick_get(b);
      chk(b == 1'b1 && xmit_done == 1'b0, "R7 stop bit after break", b, 1);
      tick_get(b);
      chk(xmit_done == 1'b1, "R7 single stop bit", xmit_done, 1);

      // R6 held break
      @(negedge clk) send_brk = 1'b1;
      bad = 1'b0;
      zeros = 0;
      for (int t = 0; t < 25; t++) begin
         tick_get(b);
         if (b !== 1'b0) bad = 1'b1;
         else zeros++;
      end
      chk(!bad, "R6 low while held", bad, 0);
      @(negedge clk) send_brk = 1'b0;
      for (int t = 0; t < 40; t++) begin
         tick_get(b);
         if (b == 1'b1) break;
         zeros++;
      end
      chk(zeros == 30, "R6 break count", zeros, 30);
      chk(xmit_done == 1'b0, "R7 stop after held break", xmit_done, 0);
      tick_get(b);
      chk(xmit_done == 1'b1, "R7 idle after stop", xmit_done, 1);

      // R8 break wins over waiting byte
      wr(8'h81);
      @(negedge clk) send_brk = 1'b1;
      @(negedge clk) send_brk = 1'b0;
      bad = 1'b0;
      for (int t = 0; t < 10; t++) begin
         tick_get(b);
         if (b !== 1'b0 || hold_empty !== 1'b0) bad = 1'b1;
      end
      chk(!bad, "R8 break first byte waits", bad, 0);
      tick_get(b);
      chk(b == 1'b1 && hold_empty == 1'b0, "R8 stop with byte waiting", b, 1);
      exp = {1'b1, 8'h81, 1'b0};
      for (int i = 0; i < 10; i++) begin
         tick_get(b);
         got[i] = b;
         if (i == 0) chk(hold_empty == 1'b1, "R8 byte loads after stop", hold_empty, 1);
      end
      chk(got == exp, "R8 byte unchanged", int'(got), int'(exp));
      tick_get(b);
      chk(xmit_done == 1'b1, "R9 idle at end", xmit_done, 1);

      finish_run();
   end
endmodule